// File: doc/BRIEF.md
# Routed Level/Edge Interrupt Controller

This block gathers 32 interrupt inputs and delivers each of them to a chosen interrupt line on a chosen processor core. It drives sixteen outputs: four cores, each with four lines. Software configures the block through a simple synchronous register port that supports word access with per-byte enables.

Each source has its own configuration:
- a routing byte that picks the target core and the target line;
- an enable bit;
- a polarity bit;
- a trigger-mode bit that selects level or edge.

The enable bits cannot be written directly. They change only through a write-one-to-set register and a write-one-to-clear register. A status register shows which enabled sources are pending. If software reads that register and finds it all zero, it treats the interrupt as spurious.

Every input passes through a two-flop synchroniser. The polarity bit is applied next, so that level and edge detection both see an active-high signal. An edge-mode source stays pending in a latch until software writes a one to its bit in the clear register.

Top module: `irq_router`

## Requirements
- R1: After reset, the following hold:
  - the enable register (0x24) reads 0;
  - the trigger-mode register (0x34) reads 0, so every source is level triggered;
  - the polarity register (0x30) reads 0xFFFFFFFF;
  - every routing word reads 0;
  - `irq_out` is 0.
- R2: Source s has its routing byte at byte offset s, for s from 0 to 31. Within a word, byte lane b holds source 4·word+b. Bits 7:4 select lines 3..0 one-hot and bits 3:0 select cores 3..0 one-hot. A write changes only the lanes whose `be` bit is set.
- R3: Writing a 1 to a bit at word 0x28 sets that source's enable. Writing a 0 leaves the bit unchanged. The enable state reads back at 0x24.
- R4: Writing a 1 to a bit at word 0x2C clears that source's enable. Writing a 0 leaves the bit unchanged.
- R5: The trigger mode is set by the mode bit (0x34) and the polarity bit (0x30) together:

  | Mode bit | Polarity bit | Trigger |
  |---|---|---|
  | 0 | 1 | active-high level |
  | 0 | 0 | active-low level |
  | 1 | 1 | rising edge |
  | 1 | 0 | falling edge |
- R6: The status word at 0x40 equals, for each source, its condition ANDed with its enable bit. The condition is the polarity-corrected input for a level source and the edge latch for an edge source. The status word may read all zero.
- R7: An edge latch is set by an active edge while the source is enabled. It holds until a 1 is written to that source's bit at 0x2C, and that write clears it.
- R8: Output `irq_out[4·c+p]` is the OR of every pending source whose routing byte has core bit c and line bit p set. A byte with several bits set drives every core and line pair it selects.
- R9: A change of a level-triggered input appears on `irq_out` after the third rising clock edge, and not before.
- R10: Reads of an unaligned address, of any unmapped offset, or of 0x28 and 0x2C return 0. Writes to unmapped offsets change no state.
- R11: Read data appears on `rdata` one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address; only word-aligned addresses are decoded |
| be | input | 4 | Byte enables for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 16 | Routed interrupt lines, index 4·core+line |
| irq_in | input | 32 | Asynchronous interrupt sources |

## Verification
The bench covers the following corner cases:
- **Active-low level sources.** It gives random polarities, and a design that inverted polarity the wrong way would assert lines for idle inputs.
- **Several bits set in one routing nibble.** It uses random routing bytes, and a priority-encoded router would drop the extra targets.
- **Edge latch lifetime.** It checks that a short pulse stays pending after the input returns, and that the pending state vanishes once the clear register is written. A design without the latch would drop the pulse, and one that cleared the latch in the wrong place would leave a stale interrupt.
- **Synchroniser latency.** It pins the level-path latency to exactly three edges.
- **Zero-write and unmapped accesses.** It confirms that zero writes to the set and clear registers change nothing, and that unmapped accesses neither return data nor corrupt state.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    // Register word offsets (byte addresses)
    localparam logic [7:0] OFF_EN_STAT  = 8'h24;
    localparam logic [7:0] OFF_EN_SET   = 8'h28;
    localparam logic [7:0] OFF_EN_CLR   = 8'h2C;
    localparam logic [7:0] OFF_POLARITY = 8'h30;
    localparam logic [7:0] OFF_TRIGMODE = 8'h34;
    localparam logic [7:0] OFF_PENDING  = 8'h40;
    // Routing byte layout: upper nibble = line one-hot, lower nibble = core one-hot
    localparam int NCORE      = 4;
    localparam int NLINE      = 4;
    localparam int LINE_LSB   = 4;
    localparam int NOUT       = NCORE * NLINE;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/irq_cond.sv
module irq_cond #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend,
    output logic [W-1:0] lat
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] lat;
    } cond_st_t;

    cond_st_t st_d, st_q;
    logic [W-1:0] norm;
    logic [W-1:0] rise;

    // polarity correction ahead of both detectors
    assign norm = raw ^ ~pol;
    assign rise = norm & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = norm;
        st_d.lat  = (st_q.lat | (rise & en & edge_sel)) & ~clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = en & ((edge_sel & st_q.lat) | (~edge_sel & norm));
    assign lat  = st_q.lat;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int NSRC  = 32,
    parameter int NCORE = 4,
    parameter int NLINE = 4,
    parameter int LSB   = 4
) (
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC*8-1:0]      route,
    output logic [NCORE*NLINE-1:0] lines
);
    for (genvar gc = 0; gc < NCORE; gc++) begin : g_core
        for (genvar gp = 0; gp < NLINE; gp++) begin : g_line
            logic [NSRC-1:0] hit;
            for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
                assign hit[gs] = pend[gs] & route[gs*8 + LSB + gp] & route[gs*8 + gc];
            end
            assign lines[gc*NLINE + gp] = |hit;
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req,
    input  logic                            we,
    input  logic [AW-1:0]                   addr,
    input  logic [3:0]                      be,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    output logic [irq_router_pkg::NOUT-1:0] irq_out,
    input  logic [NSRC-1:0]                 irq_in
);
    import irq_router_pkg::*;

    localparam logic [AW-1:0] A_EN  = AW'(OFF_EN_STAT);
    localparam logic [AW-1:0] A_SET = AW'(OFF_EN_SET);
    localparam logic [AW-1:0] A_CLR = AW'(OFF_EN_CLR);
    localparam logic [AW-1:0] A_POL = AW'(OFF_POLARITY);
    localparam logic [AW-1:0] A_TRG = AW'(OFF_TRIGMODE);
    localparam logic [AW-1:0] A_PND = AW'(OFF_PENDING);

    typedef struct packed {
        logic [NSRC-1:0][7:0] route;
        logic [NSRC-1:0]      en;
        logic [NSRC-1:0]      pol;
        logic [NSRC-1:0]      edg;
        logic [31:0]          rdata;
        logic [NOUT-1:0]      out;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] sync_in, pend, lat, clr_vec;
    logic [NOUT-1:0] lines;
    logic [31:0]     bmask, wm, rd_val;
    logic            is_wr, in_route;

    assign bmask    = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    assign wm       = wdata & bmask;
    assign is_wr    = req && we;
    assign in_route = (addr[1:0] == 2'b00) && (int'(addr) < NSRC);
    assign clr_vec  = (is_wr && addr == A_CLR) ? wm[NSRC-1:0] : '0;

    irq_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_in)
    );

    irq_cond #(.W(NSRC)) u_cond (
        .clk(clk), .rst_n(rst_n), .raw(sync_in), .pol(st_q.pol),
        .edge_sel(st_q.edg), .en(st_q.en), .clr(clr_vec),
        .pend(pend), .lat(lat)
    );

    irq_route #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE), .LSB(LINE_LSB)) u_route (
        .pend(pend), .route(st_q.route), .lines(lines)
    );

    // read mux
    always_comb begin
        rd_val = '0;
        case (addr)
            A_EN:    rd_val = 32'(st_q.en);
            A_POL:   rd_val = 32'(st_q.pol);
            A_TRG:   rd_val = 32'(st_q.edg);
            A_PND:   rd_val = 32'(pend);
            default: begin
                for (int s = 0; s < NSRC; s++) begin
                    if (in_route && int'(addr[AW-1:2]) == s / 4)
                        rd_val[(s % 4)*8 +: 8] = st_q.route[s];
                end
            end
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NSRC; s++) begin
            if (is_wr && in_route && int'(addr[AW-1:2]) == s / 4 && be[s % 4])
                st_d.route[s] = wdata[(s % 4)*8 +: 8];
        end
        if (is_wr && addr == A_SET) st_d.en = st_q.en | wm[NSRC-1:0];
        st_d.en = st_d.en & ~clr_vec;
        if (is_wr && addr == A_POL)
            st_d.pol = (st_q.pol & ~bmask[NSRC-1:0]) | wm[NSRC-1:0];
        if (is_wr && addr == A_TRG)
            st_d.edg = (st_q.edg & ~bmask[NSRC-1:0]) | wm[NSRC-1:0];
        if (req && !we) st_d.rdata = rd_val;
        st_d.out = lines;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pol <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign irq_out = st_q.out;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            we,
    input logic [AW-1:0]   addr,
    input logic [3:0]      be,
    input logic [31:0]     wdata,
    input logic [31:0]     rdata,
    input logic [15:0]     irq_out,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] lat_q
);
    logic mapped;
    assign mapped = (addr[1:0] == 2'b00) &&
                    ((int'(addr) < NSRC) || addr == AW'(8'h24) || addr == AW'(8'h30) ||
                     addr == AW'(8'h34) || addr == AW'(8'h40));

    // R3: written ones become enabled
    a_r3_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == AW'(8'h28) && be == 4'hF)
        |=> ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    // R4: written ones become disabled
    a_r4_clr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == AW'(8'h2C) && be == 4'hF)
        |=> ((en_q & $past(wdata[NSRC-1:0])) == '0));

    // R7: latch bits only fall after a clear-register write
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && addr == AW'(8'h2C))
        |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

    // R8: with nothing enabled, no line rises on the next cycle
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> (irq_out == '0));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !mapped) |=> (rdata == '0));
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .en_q(st_q.en), .lat_q(lat)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req = 0, we = 0;
    logic [7:0]  addr = 0;
    logic [3:0]  be = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [15:0] irq_out;
    logic [31:0] irq_in = 0;

    int n_chk = 0, n_bad = 0;

    logic [7:0]  m_route [32];
    logic [31:0] m_en, m_pol;

    always #5 clk = ~clk;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
        .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .irq_in(irq_in)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        req = 1; we = 1; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        req = 0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] f_out(input logic [31:0] p);
        logic [15:0] o = '0;
        for (int c = 0; c < 4; c++)
            for (int l = 0; l < 4; l++)
                for (int s = 0; s < 32; s++)
                    if (p[s] && m_route[s][4+l] && m_route[s][c]) o[c*4+l] = 1'b1;
        return o;
    endfunction

    function automatic logic [31:0] f_level(input logic [31:0] in);
        return m_en & (in ^ ~m_pol);
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v, r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int s = 0; s < 32; s++) m_route[s] = '0;
        m_en = '0; m_pol = '1;

        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 32'h0);
        rd(8'h24, r); check("R1 enable", r, 32'h0);
        rd(8'h34, r); check("R1 trigmode", r, 32'h0);
        rd(8'h30, r); check("R1 polarity", r, 32'hFFFF_FFFF);
        rd(8'h1C, r); check("R1 route word", r, 32'h0);

        // R5/R6/R8 random level traffic
        for (int it = 0; it < 30; it++) begin
            for (int w = 0; w < 8; w++) begin
                v = $urandom();
                wr(8'(w*4), v, 4'hF);
                for (int b = 0; b < 4; b++) m_route[w*4+b] = v[b*8 +: 8];
            end
            m_pol = $urandom();
            wr(8'h30, m_pol, 4'hF);
            wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
            m_en = $urandom();
            wr(8'h28, m_en, 4'hF);
            rd(8'h24, r); check("R3 enable readback", r, m_en);
            @(negedge clk); irq_in = $urandom();
            idle(5);
            check("R8 R5 routed lines", 32'(irq_out), 32'(f_out(f_level(irq_in))));
            rd(8'h40, r); check("R6 status", r, f_level(irq_in));
            v = $urandom();
            wr(8'h2C, v, 4'hF); m_en = m_en & ~v;
            rd(8'h24, r); check("R4 partial clear", r, m_en);
        end

        // R3/R4 zero writes
        wr(8'h28, 32'h0, 4'hF); rd(8'h24, r); check("R3 zero set", r, m_en);
        wr(8'h2C, 32'h0, 4'hF); rd(8'h24, r); check("R4 zero clear", r, m_en);

        // R2 byte-lane routing write
        rd(8'h04, v);
        wr(8'h04, 32'hA5A5_A5A5, 4'b0100);
        rd(8'h04, r); check("R2 byte lane", r, {v[31:24], 8'hA5, v[15:0]});

        // R10 unmapped
        wr(8'h50, 32'hFFFF_FFFF, 4'hF);
        wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
        rd(8'h50, r); check("R10 unmapped read", r, 32'h0);
        rd(8'h28, r); check("R10 set reg read", r, 32'h0);
        rd(8'h05, r); check("R10 unaligned read", r, 32'h0);
        rd(8'h24, r); check("R10 no side effect", r, m_en);

        // R9 latency: source 0 -> core0 line0
        wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
        for (int w = 0; w < 8; w++) wr(8'(w*4), 32'h0, 4'hF);
        wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        wr(8'h00, 32'h0000_0011, 4'hF);
        irq_in = '0;
        wr(8'h28, 32'h1, 4'hF);
        idle(4);
        irq_in[0] = 1'b1;
        idle(2); check("R9 not before third edge", 32'(irq_out), 32'h0);
        idle(1); check("R9 after third edge", 32'(irq_out), 32'h1);
        irq_in[0] = 1'b0;
        wr(8'h2C, 32'h1, 4'hF);

        // R7 rising edge: source 5 -> core2 line1 -> irq_out[9]
        wr(8'h04, 32'h0000_2400, 4'b0010);
        wr(8'h34, 32'h0000_0020, 4'hF);
        wr(8'h28, 32'h0000_0020, 4'hF);
        idle(5); check("R5 rising idle", 32'(irq_out), 32'h0);
        irq_in[5] = 1'b1; idle(3); irq_in[5] = 1'b0;
        idle(6); check("R7 latch holds", 32'(irq_out), 32'h200);
        rd(8'h40, r); check("R6 edge status", r, 32'h20);
        wr(8'h2C, 32'h0000_0020, 4'hF);
        idle(2); check("R7 clear drops line", 32'(irq_out), 32'h0);
        wr(8'h28, 32'h0000_0020, 4'hF);
        idle(5); check("R7 latch gone", 32'(irq_out), 32'h0);

        // R5 falling edge
        wr(8'h2C, 32'h0000_0020, 4'hF);
        irq_in[5] = 1'b1;
        wr(8'h30, 32'hFFFF_FFDF, 4'hF);
        idle(5);
        wr(8'h2C, 32'h0000_0020, 4'hF);
        wr(8'h28, 32'h0000_0020, 4'hF);
        idle(4); check("R5 falling before", 32'(irq_out), 32'h0);
        irq_in[5] = 1'b0;
        idle(6); check("R5 falling latched", 32'(irq_out), 32'h200);

        // R11 read latency
        @(negedge clk); req = 1; we = 0; addr = 8'h34;
        @(negedge clk); req = 0;
        check("R11 read next cycle", rdata, 32'h20);

        summary();
    end
endmodule